// File: doc/BRIEF.md
# Nonvolatile Memory Write Guard

This block sits between a processor bus and the programming engine of an on-chip nonvolatile memory. It holds a small control register and decodes a second bus address that stores nothing. A program or erase operation may start only when software has first set a write-enable bit. It must then write a two-byte key to the keyless address, first 55h and then AAh. The very next bus access must be a control write that sets the start bit.

Once a start is accepted, the block sends a one-cycle start pulse to the memory engine. It holds a stall output high until the engine reports completion. A warm reset, from the external reset pin or the watchdog, aborts a running operation. In that case a sticky error bit is set, and it survives the warm reset so that software can decide whether to rewrite. Only a power-on reset or a software write of zero clears it.

Top module: `nvm_write_guard`

## Requirements
- R1: Power-on reset (`por_n` low, asynchronous) clears every control bit, including the error bit. After release, `cpu_stall`, `mem_start`, `mem_rd_start`, `mem_sel_flash`, `mem_sel_cfg` and `mem_erase` are 0, and a read of the control register returns 00h.
- R2: The control register is at address 0. Its bits are: bit 7 flash select (drives `mem_sel_flash`), bit 6 configuration-space select (drives `mem_sel_cfg`), bit 5 reads 0, bit 4 erase (drives `mem_erase`), bit 3 write error, bit 2 write enable, bit 1 write start (mirrors `cpu_stall`) and bit 0 read start.
- R3: Address 1 is the keyless unlock register. Writes to it store nothing, and a read of it returns 00h.
- R4: A control write with bit 1 set starts an operation only under three conditions. It must be the next bus access after a write of 55h and then AAh to address 1. Write enable must already be 1. No operation may be running. When accepted, `mem_start` is high for exactly the cycle after the write, and `cpu_stall` rises in that same cycle.
- R5: Any bus access (read or write, at any address) other than the next expected key step sends the key tracker back to the start. This covers a wrong order, a wrong value, or an access between the AAh write and the start write. Cycles with no bus access do not disturb it.
- R6: A start request that fails R4 produces no `mem_start` pulse, leaves `cpu_stall` at 0, and leaves bit 1 reading 0. The other written fields are still stored.
- R7: `cpu_stall` stays high until a cycle with `mem_done` high, and is 0 from the following cycle. `mem_done` has no effect while no operation runs.
- R8: Control writes made while an operation runs are ignored entirely.
- R9: A warm reset (`ext_rst` or `wdt_rst` high at a clock edge) clears all control bits except the error bit. The error bit is set if an operation was running and is otherwise kept. The stall output drops after that edge.
- R10: The error bit is cleared only by a control write with bit 3 at 0, or by power-on reset. A write with bit 3 at 1 never sets it.
- R11: Writing bit 0 as 1 (when idle) sets the read-start bit for exactly one cycle and drives `mem_rd_start` high in that cycle. The bit then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External warm reset, active high, synchronous |
| wdt_rst | input | 1 | Watchdog warm reset, active high, synchronous |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, valid in the cycle of `bus_re` |
| mem_done | input | 1 | Memory engine reports completion |
| mem_start | output | 1 | One-cycle program/erase start pulse |
| mem_rd_start | output | 1 | One-cycle read start pulse |
| cpu_stall | output | 1 | Processor stall while an operation runs |
| mem_sel_flash | output | 1 | Target is program flash (1) or data EEPROM (0) |
| mem_sel_cfg | output | 1 | Target is configuration space (1) or main array (0) |
| mem_erase | output | 1 | Operation erases instead of programs |

## Verification
The bench goes after key sequences that look almost right. These are the reversed key, a key with a wrong byte, and a read slipped in between the AAh and the start write. A tracker that only remembered "seen AAh" would start the memory in each of these cases. Idle cycles inside the key must still allow a start, so a tracker that counts clock cycles rather than accesses would fail there. The bench also sets the start bit with write enable clear and writes the control register during a running operation; a guard that sampled enable from the same write, or let busy writes through, would start or alter the operation. A warm reset is injected mid-operation, and the error bit is then checked to be set, kept across a second warm reset, not set by writing 1, and cleared only by writing 0 or by power-on reset.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

    localparam int REG_W = 8;

    localparam int BIT_FLASH = 7;
    localparam int BIT_CFG   = 6;
    localparam int BIT_ERASE = 4;
    localparam int BIT_ERR   = 3;
    localparam int BIT_WREN  = 2;
    localparam int BIT_GO    = 1;
    localparam int BIT_RD    = 0;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        key_state_e st;
    } key_regs_s;

    typedef struct packed {
        logic flash;
        logic cfg;
        logic erase;
        logic err;
        logic wren;
        logic go;
        logic rd;
        logic start;
    } ctrl_regs_s;

endpackage

// File: rtl/nvm_key_tracker.sv
module nvm_key_tracker
    import nvm_guard_pkg::*;
#(
    parameter int                ADDR_W      = 2,
    parameter int                UNLOCK_ADDR = 1,
    parameter logic [REG_W-1:0]  KEY_FIRST   = 8'h55,
    parameter logic [REG_W-1:0]  KEY_SECOND  = 8'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              armed
);

    localparam logic [ADDR_W-1:0] UNLOCK_A = UNLOCK_ADDR[ADDR_W-1:0];

    key_regs_s k_d, k_q;
    logic      access;
    logic      key_wr;

    assign access = bus_we | bus_re;
    assign key_wr = bus_we && (bus_addr == UNLOCK_A);

    always_comb begin
        k_d = k_q;
        if (warm_rst) begin
            k_d.st = KEY_IDLE;
        end else if (access) begin
            unique case (k_q.st)
                KEY_IDLE:  k_d.st = (key_wr && bus_wdata == KEY_FIRST)  ? KEY_HALF  : KEY_IDLE;
                KEY_HALF:  k_d.st = (key_wr && bus_wdata == KEY_SECOND) ? KEY_ARMED : KEY_IDLE;
                default:   k_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            k_q <= '{st: KEY_IDLE};
        end else begin
            k_q <= k_d;
        end
    end

    assign armed = (k_q.st == KEY_ARMED);

    AST_ARM_FROM_KEY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(armed) |-> $past(key_wr && bus_wdata == KEY_SECOND && !warm_rst))
        else $error("armed without second key byte"); // R5

    AST_ARM_LASTS_ONE_ACCESS: assert property (@(posedge clk) disable iff (!por_n)
        armed && access |=> !armed)
        else $error("armed state survived an access"); // R5

endmodule

// File: rtl/nvm_ctrl_core.sv
module nvm_ctrl_core
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              armed,
    input  logic              mem_done,
    output logic [REG_W-1:0]  ctrl_image,
    output logic              mem_start,
    output logic              mem_rd_start,
    output logic              busy,
    output logic              sel_flash,
    output logic              sel_cfg,
    output logic              erase
);

    localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];

    ctrl_regs_s r_d, r_q;
    logic       ctrl_wr;
    logic       take_wr;
    logic       unused_wbit5;

    assign ctrl_wr      = bus_we && (bus_addr == CTRL_A);
    assign take_wr      = ctrl_wr && !r_q.go;
    assign unused_wbit5 = bus_wdata[5];

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.rd    = 1'b0;
        if (warm_rst) begin
            r_d     = '0;
            r_d.err = r_q.err | r_q.go;
        end else begin
            if (r_q.go && mem_done) begin
                r_d.go = 1'b0;
            end
            if (take_wr) begin
                r_d.flash = bus_wdata[BIT_FLASH];
                r_d.cfg   = bus_wdata[BIT_CFG];
                r_d.erase = bus_wdata[BIT_ERASE];
                r_d.wren  = bus_wdata[BIT_WREN];
                r_d.err   = r_q.err & bus_wdata[BIT_ERR];
                r_d.rd    = bus_wdata[BIT_RD] & !r_q.rd;
                if (bus_wdata[BIT_GO] && armed && r_q.wren) begin
                    r_d.go    = 1'b1;
                    r_d.start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_image   = {r_q.flash, r_q.cfg, 1'b0, r_q.erase,
                           r_q.err, r_q.wren, r_q.go, r_q.rd};
    assign mem_start    = r_q.start;
    assign mem_rd_start = r_q.rd;
    assign busy         = r_q.go;
    assign sel_flash    = r_q.flash;
    assign sel_cfg      = r_q.cfg;
    assign erase        = r_q.erase;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        r_q.start |=> !r_q.start)
        else $error("start held longer than one cycle"); // R4

    AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(r_q.start) |-> $past(armed && r_q.wren))
        else $error("start without key or enable"); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        r_q.go && !mem_done && !warm_rst |=> r_q.go)
        else $error("stall dropped before done"); // R7

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
        r_q.go && !warm_rst |=> $stable(r_q.wren) && $stable(r_q.flash) && $stable(r_q.erase))
        else $error("control changed while busy"); // R8

    AST_ABORT_SETS_ERR: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst && r_q.go |=> r_q.err && !r_q.go)
        else $error("abort did not flag error"); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        r_q.err && !(take_wr && !bus_wdata[BIT_ERR]) |=> r_q.err)
        else $error("error bit lost"); // R10

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        r_q.rd |=> !r_q.rd)
        else $error("read start held"); // R11

endmodule

// File: rtl/nvm_read_mux.sv
module nvm_read_mux
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0
) (
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  ctrl_image,
    output logic [REG_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_re && bus_addr == CTRL_A) begin
            bus_rdata = ctrl_image;
        end
    end

endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
    import nvm_guard_pkg::*;
#(
    parameter int               ADDR_W      = 2,
    parameter int               CTRL_ADDR   = 0,
    parameter int               UNLOCK_ADDR = 1,
    parameter logic [REG_W-1:0] KEY_FIRST   = 8'h55,
    parameter logic [REG_W-1:0] KEY_SECOND  = 8'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst,
    input  logic              wdt_rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              mem_done,
    output logic              mem_start,
    output logic              mem_rd_start,
    output logic              cpu_stall,
    output logic              mem_sel_flash,
    output logic              mem_sel_cfg,
    output logic              mem_erase
);

    logic             warm_rst;
    logic             armed;
    logic [REG_W-1:0] ctrl_image;

    assign warm_rst = ext_rst | wdt_rst;

    nvm_key_tracker #(
        .ADDR_W      (ADDR_W),
        .UNLOCK_ADDR (UNLOCK_ADDR),
        .KEY_FIRST   (KEY_FIRST),
        .KEY_SECOND  (KEY_SECOND)
    ) u_key (
        .clk       (clk),
        .por_n     (por_n),
        .warm_rst  (warm_rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    nvm_ctrl_core #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .warm_rst     (warm_rst),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .armed        (armed),
        .mem_done     (mem_done),
        .ctrl_image   (ctrl_image),
        .mem_start    (mem_start),
        .mem_rd_start (mem_rd_start),
        .busy         (cpu_stall),
        .sel_flash    (mem_sel_flash),
        .sel_cfg      (mem_sel_cfg),
        .erase        (mem_erase)
    );

    nvm_read_mux #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_rmux (
        .bus_re     (bus_re),
        .bus_addr   (bus_addr),
        .ctrl_image (ctrl_image),
        .bus_rdata  (bus_rdata)
    );

    AST_STALL_BIT_MATCH: assert property (@(posedge clk) disable iff (!por_n)
        bus_re && bus_addr == CTRL_ADDR[ADDR_W-1:0] |-> bus_rdata[BIT_GO] == cpu_stall)
        else $error("stall output and start bit disagree"); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rdata[5])
        else $error("reserved bit read as one"); // R2

endmodule

// File: tb/nvm_write_guard_test.sv
`timescale 1ns/1ps
module nvm_write_guard_test;

    localparam int OP_N = 0;
    localparam int OP_W = 1;
    localparam int OP_R = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       wdt_rst = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mem_done = 1'b0;
    logic       mem_start, mem_rd_start, cpu_stall;
    logic       mem_sel_flash, mem_sel_cfg, mem_erase;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nvm_write_guard uut (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_done(mem_done),
        .mem_start(mem_start), .mem_rd_start(mem_rd_start), .cpu_stall(cpu_stall),
        .mem_sel_flash(mem_sel_flash), .mem_sel_cfg(mem_sel_cfg), .mem_erase(mem_erase)
    );

    function automatic logic [31:0] v(input int op, input int a, input logic [7:0] d,
                                      input logic dn, input logic st, input logic sp,
                                      input logic [7:0] er, input int rq);
        return {op[1:0], a[1:0], d, dn, st, sp, er, rq[3:0], 5'd0};
    endfunction

    localparam int NV = 39;
    localparam logic [31:0] TBL [NV] = '{
        v(OP_R,0,8'h00,0,0,0,8'h00,1),  // R1 control reads zero after reset
        v(OP_W,0,8'h84,0,0,0,8'h00,2),  // R2 flash select + enable
        v(OP_R,0,8'h00,0,0,0,8'h84,2),
        v(OP_W,1,8'h55,0,0,0,8'h00,4),  // R4 key byte one
        v(OP_W,1,8'hAA,0,0,0,8'h00,4),  // R4 key byte two
        v(OP_W,0,8'h86,0,1,1,8'h00,4),  // R4 accepted start
        v(OP_N,0,8'h00,0,1,0,8'h00,7),  // R7 stall held, pulse gone
        v(OP_W,0,8'h00,0,1,0,8'h00,8),  // R8 write while busy
        v(OP_R,0,8'h00,0,1,0,8'h86,8),  // R8 register unchanged
        v(OP_N,0,8'h00,1,0,0,8'h00,7),  // R7 done ends stall
        v(OP_R,0,8'h00,0,0,0,8'h84,7),
        v(OP_W,1,8'hAA,0,0,0,8'h00,5),  // R5 reversed key
        v(OP_W,1,8'h55,0,0,0,8'h00,5),
        v(OP_W,0,8'h86,0,0,0,8'h00,5),
        v(OP_R,0,8'h00,0,0,0,8'h84,6),  // R6 start bit stays 0
        v(OP_W,1,8'h55,0,0,0,8'h00,5),  // R5 read between key and start
        v(OP_W,1,8'hAA,0,0,0,8'h00,5),
        v(OP_R,0,8'h00,0,0,0,8'h84,5),
        v(OP_W,0,8'h86,0,0,0,8'h00,5),
        v(OP_W,1,8'h55,0,0,0,8'h00,5),  // R5 idle cycles do not break key
        v(OP_N,0,8'h00,0,0,0,8'h00,5),
        v(OP_W,1,8'hAA,0,0,0,8'h00,5),
        v(OP_N,0,8'h00,0,0,0,8'h00,5),
        v(OP_W,0,8'h86,0,1,1,8'h00,5),
        v(OP_N,0,8'h00,1,0,0,8'h00,7),  // R7
        v(OP_W,0,8'h80,0,0,0,8'h00,6),  // R6 enable cleared
        v(OP_W,1,8'h55,0,0,0,8'h00,6),
        v(OP_W,1,8'hAA,0,0,0,8'h00,6),
        v(OP_W,0,8'h86,0,0,0,8'h00,6),  // R6 rejected, enable stored
        v(OP_R,0,8'h00,0,0,0,8'h84,6),
        v(OP_R,1,8'h00,0,0,0,8'h00,3),  // R3 unlock reads zero
        v(OP_W,1,8'h55,0,0,0,8'h00,5),  // R5 wrong second byte
        v(OP_W,1,8'h56,0,0,0,8'h00,5),
        v(OP_W,1,8'hAA,0,0,0,8'h00,5),
        v(OP_W,0,8'h86,0,0,0,8'h00,5),
        v(OP_W,1,8'h55,0,0,0,8'h00,3),  // R3 written value not stored
        v(OP_R,1,8'h00,0,0,0,8'h00,3),
        v(OP_N,0,8'h00,1,0,0,8'h00,7),  // R7 done while idle
        v(OP_R,0,8'h00,0,0,0,8'h84,7)
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_re = 1'b1; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic start_op();
        wr(2'd0, 8'h84); wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'h86);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 stall", {7'd0, cpu_stall}, 8'h00);
        chk("R1 start", {7'd0, mem_start}, 8'h00);
        chk("R1 outputs", {4'd0, mem_rd_start, mem_sel_flash, mem_sel_cfg, mem_erase}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] e;
            string tg;
            e = TBL[i];
            tg = $sformatf("R%0d step %0d", e[8:5], i);
            bus_we = (e[31:30] == 2'(OP_W));
            bus_re = (e[31:30] == 2'(OP_R));
            bus_addr = e[29:28];
            bus_wdata = e[27:20];
            mem_done = e[19];
            #1;
            if (bus_re) chk({tg, " rdata"}, bus_rdata, e[16:9]);
            @(negedge clk);
            bus_we = 1'b0; bus_re = 1'b0; mem_done = 1'b0;
            chk({tg, " stall"}, {7'd0, cpu_stall}, {7'd0, e[18]});
            chk({tg, " start"}, {7'd0, mem_start}, {7'd0, e[17]});
        end

        // R2: select and erase bits reach outputs, bit 5 reads zero
        wr(2'd0, 8'hF0);
        chk("R2 sel outputs", {5'd0, mem_sel_flash, mem_sel_cfg, mem_erase}, 8'h07);
        rd_chk(2'd0, 8'hD0, "R2 reserved bit");
        wr(2'd0, 8'h00);

        // R11: read start lasts one cycle
        wr(2'd0, 8'h01);
        chk("R11 rd pulse", {7'd0, mem_rd_start}, 8'h01);
        rd_chk(2'd0, 8'h01, "R11 rd bit");
        chk("R11 rd clear", {7'd0, mem_rd_start}, 8'h00);
        rd_chk(2'd0, 8'h00, "R11 rd bit clear");

        // R9: external reset aborts a running write
        start_op();
        chk("R9 busy before abort", {7'd0, cpu_stall}, 8'h01);
        ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
        chk("R9 stall dropped", {7'd0, cpu_stall}, 8'h00);
        chk("R9 flash sel cleared", {7'd0, mem_sel_flash}, 8'h00);
        rd_chk(2'd0, 8'h08, "R9 error after ext abort");
        ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
        rd_chk(2'd0, 8'h08, "R9 error kept over warm reset");

        // R10: only a write of zero clears; a one never sets
        wr(2'd0, 8'h08);
        rd_chk(2'd0, 8'h08, "R10 write one keeps");
        wr(2'd0, 8'h00);
        rd_chk(2'd0, 8'h00, "R10 write zero clears");
        wr(2'd0, 8'h08);
        rd_chk(2'd0, 8'h00, "R10 write one does not set");

        // R9: watchdog reset aborts too
        start_op();
        wdt_rst = 1'b1; @(negedge clk); wdt_rst = 1'b0;
        chk("R9 stall after wdt", {7'd0, cpu_stall}, 8'h00);
        rd_chk(2'd0, 8'h08, "R9 error after wdt abort");

        // R1: power-on reset clears the error bit
        por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
        rd_chk(2'd0, 8'h00, "R1 por clears error");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule